// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block finds and keeps basic frame alignment on a received 2.048 Mbit/s E1 stream. Each frame has 256 bits, made of 32 eight-bit timeslots sent most significant bit first. The stream arrives one bit per clock cycle in which `bit_en` is high. Timeslot 0 alternates between two words. The alignment word carries `0011011` in its bit positions 2 to 8. The non-alignment word has a 1 in bit position 2 and carries the remote alarm bit and five spare bits after it. Bit positions are numbered 1 (first received) to 8 (last received).

The aligner hunts bit by bit for the alignment pattern. It confirms a candidate in two steps: bit 2 of timeslot 0 in the next frame must be 1, and the alignment word one frame after that must be correct. Only then does it declare sync, which is shown on an active-low status. While in sync it keeps checking each timeslot 0. It drops sync after repeated errors of either kind, or when the caller raises a reframe request, for example because too many CRC-4 errors were counted in one second.

The block outputs:
- a frame-start strobe,
- the alignment/non-alignment phase of the current frame,
- the last received non-alignment spare bits,
- two saturating counters: one for errored alignment words, and one for frame periods spent out of sync.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset, `sync_n` is 1, `frame_start` is 0, `nfas_bits` is 0, and both counters are 0.
- R2: The state advances only in clock cycles with `bit_en` high. While hunting, every accepted bit is tested. The 7 most recent bits (bit positions 2 to 8) are compared with `0011011`, and the value of bit position 1 does not matter. A match realigns the frame count so that the matching bit becomes bit 8 of timeslot 0.
- R3: After a candidate match, if the next frame's timeslot 0 has bit 2 = 1 and the following frame's alignment word matches, `sync_n` goes to 0. This happens in the clock cycle after the bit carrying bit 8 of that second alignment word, which is 2×FRAME_BITS bits after the candidate.
- R4: If bit 2 of timeslot 0 in the frame after a candidate is 0, the hunt restarts, and no sync is declared from that candidate.
- R5: If the confirming alignment word is wrong, the hunt restarts.
- R6: In sync, MISS_LIMIT (default 3) consecutive errored alignment words cause loss of sync (`sync_n` = 1) after bit 8 of the last one. Fewer errors, followed by a correct word, keep sync.
- R7: In sync, MISS_LIMIT consecutive non-alignment words with bit 2 = 0 cause loss of sync. Fewer such words, followed by a correct one, keep sync.
- R8: A high `reframe_req` in any clock cycle forces `sync_n` to 1 in the next cycle, and a new hunt begins.
- R9: `frame_start` is high exactly in the cycles where, while in sync, `bit_en` is high and the bit presented is bit 1 of timeslot 0. It stays 0 out of sync.
- R10: `nfas_phase` is 1 during frames whose timeslot 0 is expected to be a non-alignment word. At bit 8 of each such timeslot 0 (when not hunting), `nfas_bits` latches the word's bits 3 to 8. Bit 3 (the alarm bit) goes to `nfas_bits[5]`, and bit 4 to bit 8 go to `nfas_bits[4:0]`, with bit 8 in `nfas_bits[0]`. The value holds through alignment frames.
- R11: `fas_err_cnt` increments once for each errored alignment word received in sync and saturates at all ones.
- R12: `oos_cnt` increments once per frame period (on the bit at position FRAME_BITS-1) while `sync_n` is 1, and saturates at all ones. The frame period counts from reset and restarts at each hunt match. The counter never changes while in sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies `rx_bit` in this cycle |
| rx_bit | input | 1 | Received serial data bit |
| reframe_req | input | 1 | Forces a new alignment search |
| sync_n | output | 1 | 0 when basic frame alignment is held |
| frame_start | output | 1 | Strobe with bit 1 of timeslot 0 while in sync |
| nfas_phase | output | 1 | 1 during non-alignment-word frames |
| nfas_bits | output | 6 | Latched alarm bit and spare bits |
| fas_err_cnt | output | CNT_W | Saturating count of errored alignment words |
| oos_cnt | output | CNT_W | Saturating count of out-of-sync frame periods |

## Verification
The bench builds the aligner with FRAME_BITS = 32 and CNT_W = 4, keeping MISS_LIMIT = 3. The short frame makes it cheap to sweep the start offset of the stream over more than a full frame, with bit 1 of the alignment word varied and idle cycles inserted between bits. For every offset, the exact cycle of sync and the out-of-sync frame count are computed arithmetically. The short frame also allows all 64 spare-bit patterns to be walked through. The 4-bit counters make saturation of both counters reachable within a few hundred frames.

// File: rtl/e1fa_pkg.sv
`timescale 1ns/1ps
package e1fa_pkg;
    typedef enum logic [1:0] {
        ST_HUNT     = 2'd0,
        ST_CHK_NFAS = 2'd1,
        ST_CHK_FAS  = 2'd2,
        ST_SYNC     = 2'd3
    } fa_state_e;

    localparam int          SLOT_BITS = 8;
    localparam logic [6:0]  FAS_WORD  = 7'b0011011;
endpackage

// File: rtl/e1fa_window.sv
`timescale 1ns/1ps
module e1fa_window
    import e1fa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 rx_bit,
    output logic [SLOT_BITS-1:0] word,
    output logic                 fas_hit,
    output logic                 nfas_mark
);
    logic [SLOT_BITS-2:0] sh_d, sh_q;

    // newest bit sits in word[0] (bit 8), oldest in word[7] (bit 1)
    assign word      = {sh_q, rx_bit};
    assign fas_hit   = (word[6:0] == FAS_WORD);
    assign nfas_mark = word[6];

    always_comb begin
        sh_d = sh_q;
        if (bit_en) sh_d = word[SLOT_BITS-2:0];
    end

    // all-ones reset: no stale zeros can complete a false pattern
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/e1fa_pos.sv
`timescale 1ns/1ps
module e1fa_pos
    import e1fa_pkg::*;
#(
    parameter int FRAME_BITS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic realign,
    output logic pos_zero,
    output logic ts0_end,
    output logic frame_end,
    output logic nfas_frame
);
    localparam int            PW       = $clog2(FRAME_BITS);
    localparam logic [PW-1:0] LAST     = PW'(FRAME_BITS - 1);
    localparam logic [PW-1:0] TS0_LAST = PW'(SLOT_BITS - 1);
    localparam logic [PW-1:0] RESTART  = PW'(SLOT_BITS);

    typedef struct packed {
        logic [PW-1:0] pos;
        logic          nfas;
    } pos_s;

    pos_s cur_q, nxt_d;

    assign pos_zero   = (cur_q.pos == '0);
    assign ts0_end    = bit_en && (cur_q.pos == TS0_LAST);
    assign frame_end  = bit_en && (cur_q.pos == LAST);
    assign nfas_frame = cur_q.nfas;

    always_comb begin
        nxt_d = cur_q;
        if (bit_en) begin
            if (realign) begin
                nxt_d.pos  = RESTART;
                nxt_d.nfas = 1'b0;
            end else if (cur_q.pos == LAST) begin
                nxt_d.pos  = '0;
                nxt_d.nfas = ~cur_q.nfas;
            end else begin
                nxt_d.pos = cur_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // R10
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !realign) |=> (nfas_frame != $past(nfas_frame)));
endmodule

// File: rtl/e1fa_ctrl.sv
`timescale 1ns/1ps
module e1fa_ctrl
    import e1fa_pkg::*;
#(
    parameter int MISS_LIMIT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 reframe_req,
    input  logic                 fas_hit,
    input  logic                 nfas_mark,
    input  logic                 ts0_end,
    input  logic                 nfas_frame,
    input  logic [5:0]           spare_in,
    output fa_state_e            state,
    output logic                 realign,
    output logic                 fas_err,
    output logic [5:0]           nfas_bits
);
    localparam int            MW   = $clog2(MISS_LIMIT + 1);
    localparam logic [MW-1:0] LAST = MW'(MISS_LIMIT - 1);

    typedef struct packed {
        fa_state_e     st;
        logic [MW-1:0] fas_miss;
        logic [MW-1:0] nfas_miss;
        logic [5:0]    spare;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;

    assign state     = cur_q.st;
    assign nfas_bits = cur_q.spare;
    assign realign   = bit_en && !reframe_req && (cur_q.st == ST_HUNT) && fas_hit;
    assign fas_err   = ts0_end && (cur_q.st == ST_SYNC) && !nfas_frame && !fas_hit;

    always_comb begin
        nxt_d = cur_q;
        if (reframe_req) begin
            nxt_d.st        = ST_HUNT;
            nxt_d.fas_miss  = '0;
            nxt_d.nfas_miss = '0;
        end else if (bit_en) begin
            unique case (cur_q.st)
                ST_HUNT: begin
                    if (fas_hit) nxt_d.st = ST_CHK_NFAS;
                end
                ST_CHK_NFAS: begin
                    if (ts0_end) nxt_d.st = nfas_mark ? ST_CHK_FAS : ST_HUNT;
                end
                ST_CHK_FAS: begin
                    if (ts0_end) begin
                        nxt_d.st        = fas_hit ? ST_SYNC : ST_HUNT;
                        nxt_d.fas_miss  = '0;
                        nxt_d.nfas_miss = '0;
                    end
                end
                ST_SYNC: begin
                    if (ts0_end) begin
                        if (nfas_frame) begin
                            if (nfas_mark)                       nxt_d.nfas_miss = '0;
                            else if (cur_q.nfas_miss == LAST)    nxt_d.st        = ST_HUNT;
                            else                                 nxt_d.nfas_miss = cur_q.nfas_miss + 1'b1;
                        end else begin
                            if (fas_hit)                         nxt_d.fas_miss  = '0;
                            else if (cur_q.fas_miss == LAST)     nxt_d.st        = ST_HUNT;
                            else                                 nxt_d.fas_miss  = cur_q.fas_miss + 1'b1;
                        end
                        if (nxt_d.st == ST_HUNT) begin
                            nxt_d.fas_miss  = '0;
                            nxt_d.nfas_miss = '0;
                        end
                    end
                end
                default: nxt_d.st = ST_HUNT;
            endcase
        end
        if (ts0_end && nfas_frame && (cur_q.st != ST_HUNT))
            nxt_d.spare = spare_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: ST_HUNT, fas_miss: '0, nfas_miss: '0, spare: '0};
        else        cur_q <= nxt_d;
    end

    // R8
    reframe_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reframe_req |=> (cur_q.st == ST_HUNT));

    // R3
    sync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_SYNC && $past(cur_q.st) != ST_SYNC) |-> ($past(cur_q.st) == ST_CHK_FAS));
endmodule

// File: rtl/e1fa_satcnt.sv
`timescale 1ns/1ps
module e1fa_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    assign cnt = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R11
    hold_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP));

    // R12
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + W'(1)));
endmodule

// File: rtl/e1_frame_aligner.sv
`timescale 1ns/1ps
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int MISS_LIMIT = 3,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             reframe_req,
    output logic             sync_n,
    output logic             frame_start,
    output logic             nfas_phase,
    output logic [5:0]       nfas_bits,
    output logic [CNT_W-1:0] fas_err_cnt,
    output logic [CNT_W-1:0] oos_cnt
);
    localparam int NCNT = 2;

    logic [SLOT_BITS-1:0] word;
    logic                 fas_hit, nfas_mark;
    logic                 pos_zero, ts0_end, frame_end, nfas_frame;
    logic                 realign, fas_err;
    fa_state_e            state;
    logic [NCNT-1:0]      cnt_inc;
    logic [CNT_W-1:0]     cnt_val [NCNT];

    e1fa_window u_win (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .word(word), .fas_hit(fas_hit), .nfas_mark(nfas_mark)
    );

    e1fa_pos #(.FRAME_BITS(FRAME_BITS)) u_pos (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .realign(realign),
        .pos_zero(pos_zero), .ts0_end(ts0_end), .frame_end(frame_end),
        .nfas_frame(nfas_frame)
    );

    e1fa_ctrl #(.MISS_LIMIT(MISS_LIMIT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .reframe_req(reframe_req),
        .fas_hit(fas_hit), .nfas_mark(nfas_mark), .ts0_end(ts0_end),
        .nfas_frame(nfas_frame), .spare_in(word[5:0]), .state(state),
        .realign(realign), .fas_err(fas_err), .nfas_bits(nfas_bits)
    );

    assign cnt_inc[0] = fas_err;
    assign cnt_inc[1] = frame_end && (state != ST_SYNC);

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        e1fa_satcnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(cnt_inc[gi]), .cnt(cnt_val[gi])
        );
    end

    assign fas_err_cnt = cnt_val[0];
    assign oos_cnt     = cnt_val[1];
    assign sync_n      = (state != ST_SYNC);
    assign nfas_phase  = nfas_frame;
    assign frame_start = bit_en && pos_zero && (state == ST_SYNC);

    // R2
    sync_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> $past(bit_en));

    // R10
    spare_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(nfas_bits) |-> $past(bit_en));

    // R12
    oos_idle_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oos_cnt != $past(oos_cnt)) |-> $past(sync_n));
endmodule

// File: tb/sim_e1_frame_aligner.sv
`timescale 1ns/1ps
module sim_e1_frame_aligner;
    localparam int F  = 32;
    localparam int CW = 4;
    localparam logic [7:0] FAS_OK  = 8'b10011011;
    localparam logic [7:0] FAS_BAD = 8'b10011010;
    localparam logic [7:0] NFAS_OK = 8'b11011111;
    localparam logic [7:0] NFAS_B0 = 8'b10111111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          rx_bit = 1'b1;
    logic          reframe_req = 1'b0;
    logic          sync_n, frame_start, nfas_phase;
    logic [5:0]    nfas_bits;
    logic [CW-1:0] fas_err_cnt, oos_cnt;

    int  errs = 0;
    int  checks = 0;
    bit  gap = 1'b0;
    bit  done = 1'b0;
    logic fs_seen, ph_seen;

    always #2 clk = ~clk;

    e1_frame_aligner #(.FRAME_BITS(F), .MISS_LIMIT(3), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .reframe_req(reframe_req), .sync_n(sync_n), .frame_start(frame_start),
        .nfas_phase(nfas_phase), .nfas_bits(nfas_bits),
        .fas_err_cnt(fas_err_cnt), .oos_cnt(oos_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; reframe_req = 1'b0; rx_bit = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b;
        bit_en = 1'b1;
        #1;
        fs_seen = frame_start;
        ph_seen = nfas_phase;
        @(posedge clk);
        #1;
        bit_en = 1'b0;
        if (gap) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(input logic [7:0] ts0);
        send_byte(ts0);
        repeat (F - 8) send_bit(1'b1);
    endtask

    // frame with per-bit strobe/phase observation (R9, R10)
    task automatic send_frame_chk(input logic [7:0] ts0, input bit exp_sync, input bit exp_ph);
        int fs_bad = 0;
        int ph_bad = 0;
        for (int j = 0; j < F; j++) begin
            send_bit(j < 8 ? ts0[7 - j] : 1'b1);
            if (fs_seen !== (exp_sync && j == 0)) fs_bad++;
            if (exp_sync && ph_seen !== exp_ph) ph_bad++;
        end
        chk(fs_bad == 0, "R9 frame_start placement", fs_bad, 0);
        if (exp_sync) chk(ph_bad == 0, "R10 nfas_phase", ph_bad, 0);
    endtask

    // R2 R3: s filler ones, then FAS, NFAS, FAS; sync after the last FAS bit 8
    task automatic acquire(input int s, input bit do_chk);
        logic [7:0] fw;
        fw = {s[0], FAS_OK[6:0]};
        do_reset();
        repeat (s) send_bit(1'b1);
        send_frame(fw);
        send_frame(NFAS_OK);
        for (int i = 7; i >= 1; i--) send_bit(fw[i]);
        if (do_chk) chk(sync_n === 1'b1, "R3 no sync before bit 8", sync_n, 1);
        send_bit(fw[0]);
        if (do_chk) chk(sync_n === 1'b0, "R3 sync after bit 8", sync_n, 0);
        repeat (F - 8) send_bit(1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int exp_oos;
        // R1 reset state
        do_reset();
        chk(sync_n === 1'b1, "R1 sync_n", sync_n, 1);
        chk(frame_start === 1'b0, "R1 frame_start", frame_start, 0);
        chk(nfas_bits === 6'd0, "R1 nfas_bits", nfas_bits, 0);
        chk(fas_err_cnt === '0 && oos_cnt === '0, "R1 counters", fas_err_cnt + oos_cnt, 0);

        // R2 R3 R12: offset sweep with bit-1 variation and idle gaps
        for (int s = 0; s < F + 8; s++) begin
            gap = s[0];
            acquire(s, 1'b1);
            exp_oos = (s + 8) / F + 2;
            chk(oos_cnt == CW'(exp_oos), "R12 oos count at sync", oos_cnt, exp_oos);
            if (s % 8 == 0) begin
                send_frame_chk(NFAS_OK, 1'b1, 1'b1);
                send_frame_chk(FAS_OK, 1'b1, 1'b0);
                chk(oos_cnt == CW'(exp_oos), "R12 oos frozen in sync", oos_cnt, exp_oos);
            end
        end
        gap = 1'b0;

        // R10: all spare-bit patterns
        acquire(0, 1'b0);
        for (int v = 0; v < 64; v++) begin
            send_frame({2'b11, 6'(v)});
            send_frame(FAS_OK);
            chk(nfas_bits == 6'(v), "R10 spare bits latched", nfas_bits, v);
        end
        chk(sync_n === 1'b0, "R10 sync kept", sync_n, 0);

        // R6 R11: errored alignment words
        acquire(3, 1'b0);
        send_frame(NFAS_OK); send_frame(FAS_BAD);
        send_frame(NFAS_OK); send_frame(FAS_BAD);
        send_frame(NFAS_OK); send_frame(FAS_OK);
        chk(sync_n === 1'b0, "R6 two errors keep sync", sync_n, 0);
        chk(fas_err_cnt == CW'(2), "R11 error count", fas_err_cnt, 2);
        send_frame(NFAS_OK); send_frame(FAS_BAD);
        send_frame(NFAS_OK); send_frame(FAS_BAD);
        send_frame(NFAS_OK);
        chk(sync_n === 1'b0, "R6 still in sync", sync_n, 0);
        send_byte(FAS_BAD);
        chk(sync_n === 1'b1, "R6 third error loses sync", sync_n, 1);
        chk(fas_err_cnt == CW'(5), "R11 error count", fas_err_cnt, 5);

        // R11 saturation
        acquire(0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            send_frame(NFAS_OK); send_frame(FAS_BAD);
            send_frame(NFAS_OK); send_frame(FAS_BAD);
            send_frame(NFAS_OK); send_frame(FAS_OK);
        end
        chk(fas_err_cnt == CW'(15), "R11 saturation", fas_err_cnt, 15);
        chk(sync_n === 1'b0, "R11 sync kept", sync_n, 0);

        // R7: non-alignment bit 2 errors
        acquire(5, 1'b0);
        send_frame(NFAS_B0); send_frame(FAS_OK);
        send_frame(NFAS_B0); send_frame(FAS_OK);
        send_frame(NFAS_OK); send_frame(FAS_OK);
        chk(sync_n === 1'b0, "R7 two errors keep sync", sync_n, 0);
        send_frame(NFAS_B0); send_frame(FAS_OK);
        send_frame(NFAS_B0); send_frame(FAS_OK);
        send_byte(NFAS_B0);
        chk(sync_n === 1'b1, "R7 third error loses sync", sync_n, 1);

        // R4: bit 2 = 0 after candidate restarts the hunt
        do_reset();
        repeat (5) send_bit(1'b1);
        send_frame(FAS_OK); send_frame(NFAS_B0);
        send_frame(FAS_OK);
        chk(sync_n === 1'b1, "R4 no sync from rejected candidate", sync_n, 1);
        send_frame(NFAS_OK);
        send_byte(FAS_OK);
        chk(sync_n === 1'b0, "R4 sync after restart", sync_n, 0);

        // R5: wrong confirming word restarts the hunt
        do_reset();
        repeat (9) send_bit(1'b1);
        send_frame(FAS_OK); send_frame(NFAS_OK);
        send_byte(FAS_BAD);
        chk(sync_n === 1'b1, "R5 no sync on bad confirm", sync_n, 1);
        repeat (F - 8) send_bit(1'b1);
        send_frame(NFAS_OK);
        send_frame(FAS_OK);
        send_frame(NFAS_OK);
        send_byte(FAS_OK);
        chk(sync_n === 1'b0, "R5 sync after restart", sync_n, 0);

        // R8 R9: reframe request without a bit
        acquire(2, 1'b0);
        @(negedge clk); reframe_req = 1'b1;
        @(posedge clk); #1; reframe_req = 1'b0;
        chk(sync_n === 1'b1, "R8 reframe drops sync", sync_n, 1);
        send_frame_chk(NFAS_OK, 1'b0, 1'b0);
        send_frame(FAS_OK);
        send_frame(NFAS_OK);
        send_byte(FAS_OK);
        chk(sync_n === 1'b0, "R8 resync after reframe", sync_n, 0);

        // R12 saturation while hunting
        do_reset();
        repeat (20 * F) send_bit(1'b1);
        chk(oos_cnt == CW'(15), "R12 saturation", oos_cnt, 15);
        chk(sync_n === 1'b1, "R2 no sync on idle ones", sync_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule